// File: doc/BRIEF.md
# Block-Cipher Accelerator Register Front End

This block is the software-facing shell of a 64-bit block-cipher accelerator for single or triple DES in ECB or CBC mode. Software uses a 32-bit register bus to load key words, the chaining value, the mode bits and a byte count. It then moves data one 64-bit block at a time, as two 32-bit words in each direction. The cipher rounds themselves sit behind a narrow core port, which carries a start pulse, a block, the key, the direction and the variant, and returns a done pulse with the result.

The block alternates between two phases. In the first it accepts an input block. In the second, after the core reports done, it offers the result. Each phase raises a status event that can drive the interrupt line or a DMA request. Every block that is read out lowers the remaining byte count by 8. When the count reaches zero, the block stops asking for input. In CBC mode the block applies the chaining XOR around the core and keeps the chaining register up to date.

Top module: `blkcipher_regs`

## Requirements
- R1: Key word x (0..5) is written at byte offset 0x14 - 4*(x XOR 1), that is x0 at 0x10, x1 at 0x14, x2 at 0x08, x3 at 0x0C, x4 at 0x00 and x5 at 0x04. `core_key` presents word x in bits 32x+31:32x.
- R2: The mode register at 0x20 holds CBC in bit4, triple DES in bit3 and encrypt in bit2, and these bits are read back. Bit1 (input ready) and bit0 (output ready) are read-only status bits that ignore writes.
- R3: A write to the length register at 0x24 loads the remaining count with the low three bits forced to zero. A read returns the remaining count. Each block read out reduces the count by 8.
- R4: When input is ready, a write to the high data word at 0x2C sends the block {0x2C word, 0x28 word} to the core. `core_start` pulses for exactly one cycle on the following clock, and input ready drops.
- R5: A core done sets output ready and status bit2. Reading the high data word at 0x2C (0x28 returns the low word) clears output ready. If bytes remain, input ready sets again together with status bit1; otherwise the block goes idle.
- R6: The status register at 0x3C has bit1 for input and bit2 for output. Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. The enable register is at 0x40. `irq` is high when any status bit and its enable bit are both set.
- R7: The DMA register at 0x34 holds start in bit0, input enable in bit5 and output enable in bit6. `dma_in_req` is start & input enable & input ready. `dma_out_req` is start & output enable & output ready.
- R8: In ECB mode the block reaches the core unchanged, and the core result is returned unchanged.
- R9: In CBC encrypt mode the core receives plaintext XOR chaining value, and the result becomes the new chaining value.
- R10: In CBC decrypt mode the returned word pair is core result XOR chaining value, and the input ciphertext becomes the new chaining value.
- R11: Writing 0x18 (low half) or 0x1C (high half) reloads the chaining register. The next CBC block uses the new value.
- R12: The revision register at 0x30 reads the major version in bits 10:8 and the minor version in bits 5:0.
- R13: A write to 0x2C while input ready is low starts no block and raises no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| dma_in_req | output | 1 | DMA request to write a block |
| dma_out_req | output | 1 | DMA request to read a block |
| core_start | output | 1 | One-cycle start to the cipher core |
| core_block | output | 64 | Block given to the core |
| core_key | output | 192 | Six key words |
| core_tdes | output | 1 | Triple DES selected |
| core_encrypt | output | 1 | 1 = encrypt |
| core_done | input | 1 | Core finished |
| core_result | input | 64 | Core output block |

## Verification
The assertions assume that software writes the length, mode and chaining registers only when the block is idle. They also assume that the core raises done only once per start and holds its result for that cycle. The bench follows these rules. It programs the length before each run and changes the chaining value only between blocks, after a result has been read. Its core stub pulses done exactly once, a fixed number of cycles after each start.

// File: rtl/blkcipher_regs.sv
module blkcipher_regs #(
  parameter int          LEN_W     = 16,
  parameter logic [2:0]  REV_MAJOR = 3'd2,
  parameter logic [5:0]  REV_MINOR = 6'd5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [7:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic         irq,
  output logic         dma_in_req,
  output logic         dma_out_req,
  output logic         core_start,
  output logic [63:0]  core_block,
  output logic [191:0] core_key,
  output logic         core_tdes,
  output logic         core_encrypt,
  input  logic         core_done,
  input  logic [63:0]  core_result
);
  localparam logic [7:0] A_IVLO = 8'h18, A_IVHI = 8'h1C, A_MODE = 8'h20,
                         A_LEN = 8'h24, A_DLO = 8'h28, A_DHI = 8'h2C,
                         A_REV = 8'h30, A_DMA = 8'h34, A_STAT = 8'h3C, A_IEN = 8'h40;
  localparam int KEYS = 6;

  logic [31:0]      key_q [KEYS];
  logic [63:0]      chain, in_blk, out_blk;
  logic [31:0]      in_lo;
  logic [2:0]       mode;
  logic [LEN_W-1:0] remaining;
  logic             busy, in_rdy, out_rdy;
  logic [2:0]       dma_q;
  logic [1:0]       st, ien;

  wire              wr_en   = bus_sel & bus_wr;
  wire              rd_en   = bus_sel & ~bus_wr;
  wire              cbc     = mode[2];
  wire              wr_len  = wr_en && bus_addr == A_LEN;
  wire [LEN_W-1:0]  new_len = {bus_wdata[LEN_W-1:3], 3'b000};
  wire              launch  = wr_en && bus_addr == A_DHI && in_rdy;
  wire              finish  = core_done && busy;
  wire              pop     = rd_en && bus_addr == A_DHI && out_rdy;
  wire [LEN_W-1:0]  rem_nxt = remaining - LEN_W'(8);
  wire              ev_in   = (wr_len && new_len != '0) || (pop && rem_nxt != '0);
  wire              key_hit = wr_en && bus_addr[7:5] == 3'd0 && bus_addr[1:0] == 2'd0 && bus_addr[4:2] <= 3'd5;
  wire [2:0]        key_sel = (3'd5 - bus_addr[4:2]) ^ 3'd1;

  assign core_tdes    = mode[1];
  assign core_encrypt = mode[0];
  assign core_block   = (cbc && core_encrypt) ? (in_blk ^ chain) : in_blk;
  assign irq          = |(st & ien);
  assign dma_in_req   = dma_q[0] & dma_q[1] & in_rdy;
  assign dma_out_req  = dma_q[0] & dma_q[2] & out_rdy;

  for (genvar i = 0; i < KEYS; i++) begin : g_key
    assign core_key[32*i +: 32] = key_q[i];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) key_q[i] <= '0;
      else if (key_hit && key_sel == 3'(i)) key_q[i] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0; in_blk <= '0; out_blk <= '0; in_lo <= '0; mode <= '0;
      remaining <= '0; busy <= 1'b0; in_rdy <= 1'b0; out_rdy <= 1'b0;
      core_start <= 1'b0; dma_q <= '0; st <= '0; ien <= '0;
    end else begin
      core_start <= launch;
      if (wr_en) begin
        case (bus_addr)
          A_IVLO: chain[31:0]  <= bus_wdata;
          A_IVHI: chain[63:32] <= bus_wdata;
          A_MODE: mode         <= bus_wdata[4:2];
          A_DLO:  in_lo        <= bus_wdata;
          A_DMA:  dma_q        <= {bus_wdata[6], bus_wdata[5], bus_wdata[0]};
          A_IEN:  ien          <= bus_wdata[2:1];
          default: ;
        endcase
      end
      if (launch) begin
        in_blk <= {bus_wdata, in_lo};
        busy   <= 1'b1;
        in_rdy <= 1'b0;
      end
      if (finish) begin
        busy    <= 1'b0;
        out_rdy <= 1'b1;
        out_blk <= (cbc && !core_encrypt) ? (core_result ^ chain) : core_result;
        if (cbc) chain <= core_encrypt ? core_result : in_blk;
      end
      if (pop) begin
        out_rdy   <= 1'b0;
        remaining <= rem_nxt;
        in_rdy    <= rem_nxt != '0;
      end
      if (wr_len) begin
        remaining <= new_len;
        in_rdy    <= new_len != '0;
        out_rdy   <= 1'b0;
      end
      st <= ((wr_en && bus_addr == A_STAT) ? (st & bus_wdata[2:1]) : st) | {finish, ev_in};
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        A_IVLO: bus_rdata = chain[31:0];
        A_IVHI: bus_rdata = chain[63:32];
        A_MODE: bus_rdata = {27'd0, mode, in_rdy, out_rdy};
        A_LEN:  bus_rdata = 32'(remaining);
        A_DLO:  bus_rdata = out_blk[31:0];
        A_DHI:  bus_rdata = out_blk[63:32];
        A_REV:  bus_rdata = {21'd0, REV_MAJOR, 2'd0, REV_MINOR};
        A_DMA:  bus_rdata = {25'd0, dma_q[2], dma_q[1], 4'd0, dma_q[0]};
        A_STAT: bus_rdata = {29'd0, st, 1'b0};
        A_IEN:  bus_rdata = {29'd0, ien, 1'b0};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/blkcipher_regs_chk.sv
module blkcipher_regs_chk #(parameter int LEN_W = 16) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic             core_start,
  input logic             core_done,
  input logic [63:0]      core_block,
  input logic             dma_in_req,
  input logic             busy,
  input logic             in_rdy,
  input logic             out_rdy,
  input logic [LEN_W-1:0] remaining
);
  wire hi_read = bus_sel && !bus_wr && bus_addr == 8'h2C;

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  assert_start_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> (busy && !in_rdy));
  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_rdy && out_rdy));
  assert_done_to_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && busy) |=> out_rdy);
  assert_len_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_read && out_rdy) |=> (remaining == $past(remaining) - LEN_W'(8)));
  assert_block_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(core_block));
  assert_dma_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_in_req |-> in_rdy);
endmodule

bind blkcipher_regs blkcipher_regs_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .core_start(core_start), .core_done(core_done), .core_block(core_block),
  .dma_in_req(dma_in_req), .busy(busy), .in_rdy(in_rdy), .out_rdy(out_rdy),
  .remaining(remaining));

// File: tb/blkcipher_regs_bench.sv
`timescale 1ns/1ps
module blkcipher_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, dma_in_req, dma_out_req, core_start, core_tdes, core_encrypt;
  logic [63:0] core_block, core_result;
  logic [191:0] core_key;
  logic core_done;

  always #2 clk = ~clk;

  blkcipher_regs u_blkcipher_regs (.*);

  // core stub: fixed latency, simple reversible-looking mix
  function automatic logic [63:0] stub_f(input logic [63:0] b, input logic [191:0] k,
                                         input logic e, input logic t);
    logic [63:0] r;
    r = {b[31:0], b[63:32]} ^ (e ? k[63:0] : k[127:64]);
    if (t) r = r ^ k[191:128];
    return r;
  endfunction

  logic [2:0]  cnt;
  logic [63:0] s_blk;
  logic        s_e, s_t;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin cnt <= '0; s_blk <= '0; s_e <= 1'b0; s_t <= 1'b0; end
    else if (core_start) begin cnt <= 3'd3; s_blk <= core_block; s_e <= core_encrypt; s_t <= core_tdes; end
    else if (cnt != 0) cnt <= cnt - 1'b1;
  assign core_done   = (cnt == 3'd1);
  assign core_result = stub_f(s_blk, core_key, s_e, s_t);

  int nchk = 0, nerr = 0;
  logic [31:0] K [6];
  logic [63:0] chain_m;
  logic m_cbc, m_enc, m_tdes;
  logic [63:0] exp_q [$];
  string tag_q [$];
  logic [63:0] got;
  event got_ev;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(got_ev) begin
    if (exp_q.size() == 0) chk("scoreboard-empty", got, 64'hx);
    else chk(tag_q.pop_front(), got, exp_q.pop_front());
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic set_iv(input logic [63:0] v);
    wr(8'h18, v[31:0]); wr(8'h1C, v[63:32]); chain_m = v;
  endtask

  task automatic set_mode(input logic c, input logic t, input logic e);
    m_cbc = c; m_tdes = t; m_enc = e;
    wr(8'h20, {27'd0, c, t, e, 2'b00});
  endtask

  task automatic launch(input string tag, input logic [63:0] p);
    logic [63:0] r, o;
    logic [191:0] kk;
    kk = {K[5], K[4], K[3], K[2], K[1], K[0]};
    if (m_cbc && m_enc) begin r = stub_f(p ^ chain_m, kk, 1'b1, m_tdes); o = r; chain_m = r; end
    else if (m_cbc) begin r = stub_f(p, kk, 1'b0, m_tdes); o = r ^ chain_m; chain_m = p; end
    else o = stub_f(p, kk, m_enc, m_tdes);
    exp_q.push_back(o); tag_q.push_back(tag);
    wr(8'h28, p[31:0]); wr(8'h2C, p[63:32]);
  endtask

  task automatic collect(input string tag);
    logic [31:0] c, lo, hi;
    bit ok;
    ok = 0;
    for (int i = 0; i < 40 && !ok; i++) begin rd(8'h20, c); ok = c[0]; end
    if (!ok) chk({tag, " out-ready"}, 0, 1);
    rd(8'h28, lo); rd(8'h2C, hi);
    got = {hi, lo}; -> got_ev;
    #1;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 6; i++) K[i] = 32'h1111_0000 * (i + 1) ^ 32'h0bad_5eed;
    repeat (3) @(negedge clk); rst_n = 1;

    rd(8'h20, d); chk("R2 reset mode", d, 0);
    chk("R6 reset irq", irq, 0);
    chk("R7 reset dma", {dma_in_req, dma_out_req}, 0);
    rd(8'h30, d); chk("R12 revision", d, 32'h205);

    for (int x = 0; x < 6; x++) wr(8'h14 - 8'(4 * (x ^ 1)), K[x]);
    chk("R1 key placement", core_key[63:0], {K[1], K[0]});
    chk("R1 key placement tdes", core_key[191:64], {K[5], K[4], K[3], K[2]});

    wr(8'h20, 32'h1F); rd(8'h20, d); chk("R2 read-only flags", d, 32'h1C);
    chk("R2 mode pins", {core_tdes, core_encrypt}, 2'b11);

    wr(8'h28, 32'h1234); wr(8'h2C, 32'h5678);
    chk("R13 no start when idle", core_start, 0);
    @(negedge clk); chk("R13 no start later", core_start, 0);
    rd(8'h3C, d); chk("R13 no status", d, 0);

    // R8 ECB, two blocks, with status/irq/dma checks
    set_mode(0, 0, 1);
    wr(8'h24, 32'h13); rd(8'h24, d); chk("R3 length aligned", d, 32'h10);
    rd(8'h3C, d); chk("R6 input event", d, 32'h2);
    wr(8'h40, 32'h2); chk("R6 irq enabled", irq, 1);
    wr(8'h3C, 32'h6); chk("R6 write one keeps", irq, 1);
    wr(8'h3C, 32'h0); chk("R6 write zero clears", irq, 0);
    wr(8'h34, 32'h61); chk("R7 dma in request", dma_in_req, 1);
    launch("R8 ecb block0", 64'h0123_4567_89AB_CDEF);
    chk("R4 start pulse", core_start, 1);
    chk("R7 dma in drops", dma_in_req, 0);
    @(negedge clk); chk("R4 start one cycle", core_start, 0);
    repeat (4) @(negedge clk);
    chk("R7 dma out request", dma_out_req, 1);
    rd(8'h3C, d); chk("R5 output event", d, 32'h4);
    collect("R8 ecb block0");
    rd(8'h24, d); chk("R3 count down", d, 8);
    rd(8'h20, d); chk("R5 input ready again", d, 32'h06);
    launch("R8 ecb block1", 64'hFEDC_BA98_7654_3210);
    collect("R8 ecb block1");
    rd(8'h24, d); chk("R3 count zero", d, 0);
    rd(8'h20, d); chk("R5 idle at end", d, 32'h04);
    wr(8'h34, 32'h0); wr(8'h3C, 32'h0);

    // R9 CBC encrypt, triple DES
    set_mode(1, 1, 1); set_iv(64'hA5A5_0F0F_3C3C_9696);
    wr(8'h24, 24);
    launch("R9 cbc enc 0", 64'h1111_2222_3333_4444); collect("R9 cbc enc 0");
    launch("R9 cbc enc 1", 64'h5555_6666_7777_8888); collect("R9 cbc enc 1");
    launch("R9 cbc enc 2", 64'h0000_0000_0000_0000); collect("R9 cbc enc 2");

    // R10 CBC decrypt
    set_mode(1, 1, 0); set_iv(64'h0F1E_2D3C_4B5A_6978);
    wr(8'h24, 16);
    launch("R10 cbc dec 0", 64'hDEAD_BEEF_CAFE_F00D); collect("R10 cbc dec 0");
    launch("R10 cbc dec 1", 64'h0102_0304_0506_0708); collect("R10 cbc dec 1");

    // R11 IV reload between blocks
    set_mode(1, 0, 1); set_iv(64'h1);
    wr(8'h24, 16);
    launch("R11 before reload", 64'h9999_AAAA_BBBB_CCCC); collect("R11 before reload");
    set_iv(64'h7777_0000_1234_4321);
    launch("R11 after reload", 64'h9999_AAAA_BBBB_CCCC); collect("R11 after reload");

    repeat (4) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule